// File: doc/BRIEF.md
# Serial Program/Verify Command Interface

This block is the device-side end of a two-wire programming link. An external host toggles a serial clock and presents data on a serial data line; the block oversamples both with its own system clock, assembles 20-bit frames (a 4-bit command, then a 16-bit operand), and turns each frame into one action. It can hand a 16-bit word to the CPU core as an instruction, read one byte from memory through a 22-bit table pointer, or write one operand to memory with an optional programming-start strobe. Read-type frames send one byte back to the host on the data line.

The data line is split at the block edge into an input, an output value and an output enable; the pad itself sits outside. The table pointer can be loaded directly through a parallel port, which stands in for the core instructions that would normally set it up. The memory side is a plain single-cycle request interface: read data must be valid in the same cycle as the read request.

All activity is gated by a program-mode input. While it is low the block holds its frame counter at the start of a command and keeps the data line as an input.

Top module: `serial_prog_if`

## Requirements
- R1: A frame is 20 serial clocks. The data line is captured on each falling serial clock edge. The first 4 captured bits form the command and the next 16 form the operand, both least significant bit first. After the 20th falling edge the next bit starts a new command.
- R2: Command 0000 raises `coreValid` for one system cycle at the end of the frame, with `coreInstr` equal to the 16-bit operand.
- R3: Commands 1000, 1001, 1010 and 1011 issue one memory read after the 12th falling edge. For 1000 the address is the pointer and the pointer is unchanged. For 1001 the address is the pointer and the pointer then increments by 1. For 1010 the address is the pointer and the pointer then decrements by 1. For 1011 the pointer increments by 1 first and that new value is the address. The byte read is stored in the table latch.
- R4: For read-type commands (10xx and 0010), the output enable is low for the first 12 clocks of the frame. From the rising edge of clock 13 through clock 20, the block drives one latch bit per clock, least significant bit first, with each bit changing after a rising edge. The output enable drops at the end of the frame.
- R5: Command 0010 drives out the table latch without any memory access. The latch holds the last byte read, or the low operand byte of the last table write.
- R6: Commands 1100, 1101, 1110 and 1111 issue one memory write at the end of the frame, with the current pointer as address and the operand as data. 1101 and 1110 then add 2 to the pointer, while 1100 and 1111 leave it unchanged. `progStart` accompanies the write for 1110 and 1111 only.
- R7: Pointer arithmetic wraps modulo 2^22.
- R8: Command codes 0001 and 0011 to 0111 consume a full frame with no request, no strobe, no pointer change and no output drive.
- R9: While `progMode` is low, the frame counter returns to the command phase, the output enable is low, and no request or strobe is issued. A partial frame is discarded.
- R10: `ptrLoadEn` loads `ptrLoadVal` into the table pointer on the next clock edge.
- R11: At most one of `memRdReq`, `memWrReq` and `coreValid` is high in any cycle.
- R12: When a pointer load and a serial pointer update fall in the same cycle, the load wins. The access still uses the old pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| progMode | input | 1 | Program mode enable |
| serClk | input | 1 | Host serial clock |
| serDataIn | input | 1 | Serial data from host |
| serDataOut | output | 1 | Serial data to host |
| serDataOe | output | 1 | Output enable for the data pad |
| ptrLoadEn | input | 1 | Table pointer load strobe |
| ptrLoadVal | input | 22 | Table pointer load value |
| tablePtr | output | 22 | Current table pointer |
| memRdReq | output | 1 | Memory read request |
| memWrReq | output | 1 | Memory write request |
| memAddr | output | 22 | Memory address |
| memWrData | output | 16 | Memory write data |
| memRdData | input | 8 | Memory read data, valid with request |
| progStart | output | 1 | Start-programming strobe |
| coreValid | output | 1 | Core instruction strobe |
| coreInstr | output | 16 | Core instruction word |

## Verification
The parallel pointer load and the serial pointer update at the end of a read or write can land on the same system cycle. The bench forces this collision by watching for the write request on the falling system clock edge and asserting the load for exactly the following rising edge. It then requires the pointer to hold the loaded value rather than the incremented one, and the write address to show the pre-load pointer. Every command code is swept against pointers at both ends of the 22-bit range, so each increment, decrement and pre-increment also crosses the wrap.

// File: rtl/spv_pkg.sv
package spv_pkg;
  localparam int CMD_W = 4;
  localparam int IDX_W = 3;

  typedef enum logic [2:0] {
    PTR_KEEP,
    PTR_INC1,
    PTR_DEC1,
    PTR_PRE1,
    PTR_INC2
  } ptrOp_e;

  typedef struct packed {
    logic             shiftOp;
    logic             rdStb;
    logic             wrStb;
    logic             coreStb;
    logic             startStb;
    logic             driveBit;
    logic [IDX_W-1:0] outIdx;
    logic             clearOe;
    ptrOp_e           ptrOp;
  } dpCtl_t;
endpackage

// File: rtl/spv_ctrl.sv
module spv_ctrl
  import spv_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   progMode,
  input  logic   serClk,
  input  logic   serDataIn,
  output logic   bitIn,
  output dpCtl_t ctl
);
  localparam int FRAME = CMD_W + OP_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int OUT_BITS = OP_W / 2;
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] OUT_START_C = CNT_W'(FRAME - OUT_BITS);
  localparam logic [CNT_W-1:0] RD_AT_C = CNT_W'(FRAME - OUT_BITS - 1);
  localparam logic [CNT_W-1:0] CMD_END_C = CNT_W'(CMD_W);

  logic [2:0]       clkSync;
  logic [1:0]       dSync;
  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] cmdReg;
  logic riseEv, fallEv, lastFall, rdFall;
  logic isRead, isLatchOut, isWrite, isCore;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync <= '0;
      dSync   <= '0;
    end else begin
      clkSync <= {clkSync[1:0], serClk};
      dSync   <= {dSync[0], serDataIn};
    end
  end

  assign bitIn  = dSync[1];
  assign riseEv = progMode && clkSync[1] && !clkSync[2];
  assign fallEv = progMode && !clkSync[1] && clkSync[2];

  always_ff @(posedge clk) begin
    if (!rstN || !progMode) begin
      cnt    <= '0;
      cmdReg <= '0;
    end else if (fallEv) begin
      cnt <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
      if (cnt < CMD_END_C) cmdReg <= {bitIn, cmdReg[CMD_W-1:1]};
    end
  end

  assign isRead     = (cmdReg[3:2] == 2'b10);
  assign isLatchOut = (cmdReg == 4'b0010);
  assign isWrite    = (cmdReg[3:2] == 2'b11);
  assign isCore     = (cmdReg == 4'b0000);
  assign lastFall   = fallEv && (cnt == LAST_C);
  assign rdFall     = fallEv && (cnt == RD_AT_C);

  always_comb begin
    ctl          = '0;
    ctl.ptrOp    = PTR_KEEP;
    ctl.shiftOp  = fallEv && (cnt >= CMD_END_C);
    ctl.rdStb    = rdFall && isRead;
    ctl.wrStb    = lastFall && isWrite;
    ctl.startStb = lastFall && isWrite && cmdReg[1];
    ctl.coreStb  = lastFall && isCore;
    ctl.driveBit = riseEv && (isRead || isLatchOut) && (cnt >= OUT_START_C);
    ctl.outIdx   = IDX_W'(cnt - OUT_START_C);
    ctl.clearOe  = lastFall || !progMode;
    if (ctl.rdStb) begin
      unique case (cmdReg[1:0])
        2'b00: ctl.ptrOp = PTR_KEEP;
        2'b01: ctl.ptrOp = PTR_INC1;
        2'b10: ctl.ptrOp = PTR_DEC1;
        default: ctl.ptrOp = PTR_PRE1;
      endcase
    end else if (ctl.wrStb && (cmdReg[1] ^ cmdReg[0])) begin
      ctl.ptrOp = PTR_INC2;
    end
  end
endmodule

// File: rtl/spv_datapath.sv
module spv_datapath
  import spv_pkg::*;
#(
  parameter int PTR_W = 22,
  parameter int OP_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              bitIn,
  input  logic              ptrLoadEn,
  input  logic [PTR_W-1:0]  ptrLoadVal,
  input  logic [OP_W/2-1:0] memRdData,
  output logic [PTR_W-1:0]  tablePtr,
  output logic [PTR_W-1:0]  memAddr,
  output logic [OP_W-1:0]   opNext,
  output logic              serDataOut,
  output logic              serDataOe
);
  localparam int BYTE_W = OP_W / 2;

  logic [OP_W-1:0]   opReg;
  logic [BYTE_W-1:0] latchReg;
  logic [PTR_W-1:0]  ptr;

  assign opNext   = {bitIn, opReg[OP_W-1:1]};
  assign memAddr  = (ctl.ptrOp == PTR_PRE1) ? ptr + PTR_W'(1) : ptr;
  assign tablePtr = ptr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg    <= '0;
      latchReg <= '0;
    end else begin
      if (ctl.shiftOp) opReg <= opNext;
      if (ctl.rdStb)      latchReg <= memRdData;
      else if (ctl.wrStb) latchReg <= opNext[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (ptrLoadEn) begin
      ptr <= ptrLoadVal;
    end else begin
      unique case (ctl.ptrOp)
        PTR_INC1, PTR_PRE1: ptr <= ptr + PTR_W'(1);
        PTR_DEC1:           ptr <= ptr - PTR_W'(1);
        PTR_INC2:           ptr <= ptr + PTR_W'(2);
        default:            ptr <= ptr;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearOe) begin
      serDataOut <= 1'b0;
      serDataOe  <= 1'b0;
    end else if (ctl.driveBit) begin
      serDataOut <= latchReg[ctl.outIdx];
      serDataOe  <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_prog_if.sv
module serial_prog_if
  import spv_pkg::*;
#(
  parameter int PTR_W = 22,
  parameter int OP_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progMode,
  input  logic              serClk,
  input  logic              serDataIn,
  output logic              serDataOut,
  output logic              serDataOe,
  input  logic              ptrLoadEn,
  input  logic [PTR_W-1:0]  ptrLoadVal,
  output logic [PTR_W-1:0]  tablePtr,
  output logic              memRdReq,
  output logic              memWrReq,
  output logic [PTR_W-1:0]  memAddr,
  output logic [OP_W-1:0]   memWrData,
  input  logic [OP_W/2-1:0] memRdData,
  output logic              progStart,
  output logic              coreValid,
  output logic [OP_W-1:0]   coreInstr
);
  dpCtl_t          ctl;
  logic            bitIn;
  logic [OP_W-1:0] opNext;

  spv_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .progMode(progMode), .serClk(serClk),
    .serDataIn(serDataIn), .bitIn(bitIn), .ctl(ctl)
  );

  spv_datapath #(.PTR_W(PTR_W), .OP_W(OP_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitIn(bitIn),
    .ptrLoadEn(ptrLoadEn), .ptrLoadVal(ptrLoadVal), .memRdData(memRdData),
    .tablePtr(tablePtr), .memAddr(memAddr), .opNext(opNext),
    .serDataOut(serDataOut), .serDataOe(serDataOe)
  );

  assign memRdReq  = ctl.rdStb;
  assign memWrReq  = ctl.wrStb;
  assign progStart = ctl.startStb;
  assign coreValid = ctl.coreStb;
  assign memWrData = opNext;
  assign coreInstr = opNext;
endmodule

// File: rtl/spv_checker.sv
module spv_checker #(
  parameter int PTR_W = 22
) (
  input logic             clk,
  input logic             rstN,
  input logic             progMode,
  input logic             serDataOe,
  input logic             ptrLoadEn,
  input logic [PTR_W-1:0] ptrLoadVal,
  input logic [PTR_W-1:0] tablePtr,
  input logic             memRdReq,
  input logic             memWrReq,
  input logic             progStart,
  input logic             coreValid
);
  AST_OE_OFF_OUTSIDE_PROG: assert property (@(posedge clk) disable iff (!rstN)
    !progMode |=> !serDataOe); // R9
  AST_QUIET_OUTSIDE_PROG: assert property (@(posedge clk) disable iff (!rstN)
    !progMode |-> !(memRdReq || memWrReq || coreValid)); // R9
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $countones({memRdReq, memWrReq, coreValid}) <= 1); // R11
  AST_START_WITH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> memWrReq); // R6
  AST_PTR_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ptrLoadEn && !memRdReq && !memWrReq) |=> $stable(tablePtr)); // R3
  AST_PTR_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ptrLoadEn |=> (tablePtr == $past(ptrLoadVal))); // R12
endmodule

bind serial_prog_if spv_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .progMode(progMode), .serDataOe(serDataOe),
  .ptrLoadEn(ptrLoadEn), .ptrLoadVal(ptrLoadVal), .tablePtr(tablePtr),
  .memRdReq(memRdReq), .memWrReq(memWrReq), .progStart(progStart),
  .coreValid(coreValid)
);

// File: tb/serial_prog_if_tb.sv
module serial_prog_if_tb;
  logic clk = 0, rstN = 0, progMode = 0, serClk = 0, serDataIn = 0;
  logic serDataOut, serDataOe, ptrLoadEn = 0;
  logic [21:0] ptrLoadVal = '0, tablePtr, memAddr;
  logic memRdReq, memWrReq, progStart, coreValid;
  logic [15:0] memWrData, coreInstr;
  logic [7:0] memRdData;

  int nRun = 0, nFail = 0;
  int rdCnt = 0, wrCnt = 0, coreCnt = 0, startCnt = 0, multiAct = 0;
  logic [21:0] rdAddr, wrAddr;
  logic [15:0] wrData, coreWord;
  logic [7:0] outByte;
  logic oeEarly, oeAny, armOverlap = 0, clearLoad = 0;

  always #4 clk = ~clk;

  serial_prog_if u_dut (.*);

  function automatic logic [7:0] memf(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b0, a[21:16]} ^ 8'hA5;
  endfunction
  assign memRdData = memf(memAddr);

  always @(negedge clk) begin
    if (memRdReq) begin rdCnt++; rdAddr = memAddr; end
    if (memWrReq) begin wrCnt++; wrAddr = memAddr; wrData = memWrData; end
    if (coreValid) begin coreCnt++; coreWord = coreInstr; end
    if (progStart) startCnt++;
    if (32'(memRdReq) + 32'(memWrReq) + 32'(coreValid) > 1) multiAct++;
    if (clearLoad) begin ptrLoadEn = 0; clearLoad = 0; end
    if (armOverlap && memWrReq) begin
      ptrLoadEn = 1; ptrLoadVal = 22'h2AAAA; armOverlap = 0; clearLoad = 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadPtr(input logic [21:0] v);
    @(negedge clk); ptrLoadEn = 1; ptrLoadVal = v;
    @(negedge clk); ptrLoadEn = 0;
  endtask

  // drives nClk serial clocks of a frame; records output byte and enable usage
  task automatic sendBits(input logic [3:0] cmd, input logic [15:0] op, input int nClk);
    oeEarly = 0; oeAny = 0; outByte = '0;
    for (int i = 0; i < nClk; i++) begin
      serDataIn = (i < 4) ? cmd[i] : op[i-4];
      waitN(1);
      serClk = 1;
      waitN(5);
      if (serDataOe) oeAny = 1;
      if (i < 12 && serDataOe) oeEarly = 1;
      if (i >= 12) outByte[i-12] = serDataOut;
      waitN(1);
      serClk = 0;
      waitN(6);
      if (serDataOe) oeAny = 1;
    end
    waitN(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [21:0] ptrs [4];
    logic [7:0] latchExp;
    ptrs[0] = 22'h000000; ptrs[1] = 22'h3FFFFF; ptrs[2] = 22'h3FFFFE; ptrs[3] = 22'h012345;
    latchExp = '0;
    waitN(4);
    check("R9 reset oe", 32'(serDataOe), 0);
    check("R10 reset pointer", 32'(tablePtr), 0);
    rstN = 1; waitN(2);
    progMode = 1; waitN(4);

    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 16; c++) begin
        logic [21:0] p, a, pe;
        logic [15:0] op;
        logic [3:0] cm;
        int r0, w0, c0, s0;
        string tp;
        p = ptrs[k]; cm = 4'(c);
        op = {cm, 4'h6, p[7:0] ^ 8'(c * 37)};
        tp = (k < 3) ? "R7 wrap" : "R3 pointer";
        loadPtr(p);
        check("R10 load", 32'(tablePtr), 32'(p));
        r0 = rdCnt; w0 = wrCnt; c0 = coreCnt; s0 = startCnt;
        sendBits(cm, op, 20);
        check("R4 pin input first 12 clocks", 32'(oeEarly), 0);
        check("R4 pin released after frame", 32'(serDataOe), 0);
        if (cm[3:2] == 2'b10) begin
          a = (cm[1:0] == 2'b11) ? p + 1 : p;
          pe = (cm[1:0] == 2'b00) ? p : (cm[1:0] == 2'b10) ? p - 1 : p + 1;
          check("R3 one read", 32'(rdCnt - r0), 1);
          check("R3 read address", 32'(rdAddr), 32'(a));
          check(tp, 32'(tablePtr), 32'(pe));
          check("R4 read byte out", 32'(outByte), 32'(memf(a)));
          latchExp = memf(a);
        end else if (cm[3:2] == 2'b11) begin
          pe = (cm[1] ^ cm[0]) ? p + 2 : p;
          check("R6 one write", 32'(wrCnt - w0), 1);
          check("R6 write address", 32'(wrAddr), 32'(p));
          check("R1 R6 write data", 32'(wrData), 32'(op));
          check("R6 start strobe", 32'(startCnt - s0), 32'(cm[1]));
          check(tp, 32'(tablePtr), 32'(pe));
          latchExp = op[7:0];
        end else if (cm == 4'b0000) begin
          check("R2 one core strobe", 32'(coreCnt - c0), 1);
          check("R1 R2 core word", 32'(coreWord), 32'(op));
          check("R2 pointer kept", 32'(tablePtr), 32'(p));
        end else if (cm == 4'b0010) begin
          check("R5 latch out", 32'(outByte), 32'(latchExp));
          check("R5 no memory read", 32'(rdCnt - r0), 0);
          check("R5 pointer kept", 32'(tablePtr), 32'(p));
        end else begin
          check("R8 no actions", 32'(rdCnt - r0 + wrCnt - w0 + coreCnt - c0 + startCnt - s0), 0);
          check("R8 pointer kept", 32'(tablePtr), 32'(p));
          check("R8 no drive", 32'(oeAny), 0);
        end
      end
    end

    // R12: pointer load in the same cycle as the post-increment of a write
    loadPtr(22'h000100);
    armOverlap = 1;
    sendBits(4'b1101, 16'hBEEF, 20);
    check("R12 load wins", 32'(tablePtr), 32'h2AAAA);
    check("R12 write used old pointer", 32'(wrAddr), 32'h100);

    // R9: abort during command phase and during output phase
    begin
      int c0, r0;
      c0 = coreCnt;
      sendBits(4'b0000, 16'hFFFF, 7);
      progMode = 0; waitN(4); progMode = 1; waitN(4);
      sendBits(4'b0000, 16'h1357, 20);
      check("R9 frame restarts after abort", 32'(coreCnt - c0), 1);
      check("R9 R1 clean decode after abort", 32'(coreWord), 32'h1357);
      r0 = rdCnt;
      sendBits(4'b1000, 16'h0000, 15);
      check("R4 pin driven mid output", 32'(serDataOe), 1);
      progMode = 0; waitN(3);
      check("R9 pin released on exit", 32'(serDataOe), 0);
      progMode = 1; waitN(4);
      sendBits(4'b1001, 16'h0000, 20);
      check("R9 read after abort", 32'(rdCnt - r0), 2);
    end

    check("R11 single action per cycle", 32'(multiAct), 0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule